// File: doc/BRIEF.md
# Dual-Source Selectable Watchdog Timer

This block is a watchdog counter that counts strobes from one of two tick sources inside a single synchronous clock domain. One source is a slow internal oscillator tick and the other is a system clock tick. Both arrive as single-cycle enable pulses. An 8-bit mode register sets two things: which source drives the counter (or whether it is halted), and one of eight power-of-two timeout lengths. The timeout exponent depends on the chosen source. On the slow tick the period is 2^(11+n) ticks. On the system tick it is 2^(13+n) ticks.

Software programs the mode register once during setup. A rejected write leaves the register open, but the first accepted write locks it until reset. An option-strap input decides whether the system-tick and halted choices may be selected at all. Without the strap, only the slow source is allowed. Firmware pulses the restart input to clear the count before it expires. If it fails to do so, the block raises a one-cycle overflow pulse, which the surrounding chip uses as a reset request. All pins are plain control and status signals. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `dswdt_top`

## Requirements
- R1: After reset the mode readback equals 0x67 (slow source, code 7) and the overflow output is low.
- R2: A write whose bits 7:5 differ from binary 011 is rejected and leaves the mode unchanged. Readback bits 7:5 are always 011.
- R3: With bits 4:3 = 00 the counter advances only on the slow tick, and overflow is signalled on the 2^(11+n)-th slow tick, where n is bits 2:0. System ticks have no effect in this mode.
- R4: With bits 4:3 = 01 the counter advances only on the system tick, and overflow is signalled on the 2^(13+n)-th system tick.
- R5: With bits 4:3 = 1x the counter never advances and no overflow is raised, whatever the code and the ticks.
- R6: While the strap input is low, a write selecting bits 4:3 other than 00 is ignored and the current mode stays in force.
- R7: After the first accepted write, every later write has no effect until reset.
- R8: A restart pulse clears the count. When restart coincides with the terminal tick, restart wins and no overflow is raised.
- R9: The overflow output is high for exactly one cycle, in the cycle after the terminal tick's edge, and the count restarts from zero.
- R10: An accepted mode write clears the count, so the new period is measured from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode write data |
| cfg_rdata | output | 8 | Mode register readback |
| strap_allow | input | 1 | Option strap; high permits system-tick and halted modes |
| slow_tick | input | 1 | Slow oscillator enable strobe |
| sys_tick | input | 1 | System clock enable strobe |
| restart | input | 1 | Software restart (clear) strobe |
| ovf_pulse | output | 1 | One-cycle overflow / reset request |

## Verification
Assertions check the following on every cycle: the fixed readback bits, the mode staying frozen once locked or when the strap forbids a write, the count clearing on restart and on an accepted write, the count holding while halted, and the overflow pulse being single-cycle with a zeroed count behind it. The period lengths for each source and code can only be shown by the bench scenarios. The same holds for the restart-versus-terminal-tick race and for the insensitivity to the unselected source. The bench measures the actual tick counts between overflows under randomly gapped strobes.

// File: rtl/dswdt_pkg.sv
package dswdt_pkg;
  localparam int MODE_W = 8;
  localparam logic [2:0] FIXED_TOP = 3'b011;
  localparam logic [MODE_W-1:0] MODE_RESET = 8'h67;

  typedef enum logic [1:0] {
    SRC_SLOW  = 2'b00,
    SRC_SYS   = 2'b01,
    SRC_HALT0 = 2'b10,
    SRC_HALT1 = 2'b11
  } src_sel_e;

  function automatic logic sel_is_halt(input logic [1:0] sel);
    return sel[1];
  endfunction
endpackage

// File: rtl/dswdt_mode_reg.sv
module dswdt_mode_reg
  import dswdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  input  logic              strap,
  output logic [MODE_W-1:0] mode_q,
  output logic              accept
);
  logic locked_q;
  logic top_ok;
  logic src_ok;

  assign top_ok = (wdata[7:5] == FIXED_TOP);
  assign src_ok = (wdata[4:3] == SRC_SLOW) || strap;
  assign accept = we && !locked_q && top_ok && src_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_RESET;
      locked_q <= 1'b0;
    end else if (accept) begin
      mode_q   <= wdata;
      locked_q <= 1'b1;
    end
  end

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7:5] == FIXED_TOP);
  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && we) |=> $stable(mode_q));
  p_strap_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !strap && wdata[4:3] != 2'b00) |=> $stable(mode_q));
endmodule

// File: rtl/dswdt_tick_sel.sv
module dswdt_tick_sel
  import dswdt_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       slow_tick,
  input  logic       sys_tick,
  output logic       tick,
  output logic       halted
);
  always_comb begin
    unique case (sel)
      SRC_SLOW: tick = slow_tick;
      SRC_SYS:  tick = sys_tick;
      default:  tick = 1'b0;
    endcase
  end
  assign halted = sel_is_halt(sel);
endmodule

// File: rtl/dswdt_limit_dec.sv
module dswdt_limit_dec
  import dswdt_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int SLOW_BASE = 11,
  parameter int SYS_BASE  = 13
) (
  input  logic [1:0]       sel,
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] limit
);
  localparam int PW_W = CNT_W + 1;
  logic [PW_W-1:0] pw;
  int unsigned     expo;

  always_comb begin
    expo  = (sel == SRC_SYS) ? (SYS_BASE + int'(code)) : (SLOW_BASE + int'(code));
    pw    = PW_W'(1) << expo;
    limit = pw[CNT_W-1:0] - CNT_W'(1);
  end
endmodule

// File: rtl/dswdt_counter.sv
module dswdt_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halted,
  input  logic             clr,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (restart || clr) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == limit) begin
          cnt_q <= '0;
          ovf   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0) && !ovf);
  p_accept_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  p_halt_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart && !clr) |=> $stable(cnt_q) && !ovf);
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);
  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt_q == '0));
endmodule

// File: rtl/dswdt_top.sv
module dswdt_top
  import dswdt_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int SLOW_BASE = 11,
  parameter int SYS_BASE  = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       strap_allow,
  input  logic       slow_tick,
  input  logic       sys_tick,
  input  logic       restart,
  output logic       ovf_pulse
);
  logic [MODE_W-1:0] mode_q;
  logic              accept;
  logic              tick;
  logic              halted;
  logic [CNT_W-1:0]  limit;

  dswdt_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .strap  (strap_allow),
    .mode_q (mode_q),
    .accept (accept)
  );

  dswdt_tick_sel u_tsel (
    .sel       (mode_q[4:3]),
    .slow_tick (slow_tick),
    .sys_tick  (sys_tick),
    .tick      (tick),
    .halted    (halted)
  );

  dswdt_limit_dec #(
    .CNT_W     (CNT_W),
    .SLOW_BASE (SLOW_BASE),
    .SYS_BASE  (SYS_BASE)
  ) u_lim (
    .sel   (mode_q[4:3]),
    .code  (mode_q[2:0]),
    .limit (limit)
  );

  dswdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .halted  (halted),
    .clr     (accept),
    .restart (restart),
    .limit   (limit),
    .ovf     (ovf_pulse)
  );

  assign cfg_rdata = mode_q;
endmodule

// File: tb/dswdt_top_bench.sv
`timescale 1ns/1ps
module dswdt_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       strap_allow = 1'b0;
  logic       slow_tick = 1'b0;
  logic       sys_tick = 1'b0;
  logic       restart = 1'b0;
  logic       ovf_pulse;

  int n_checks = 0;
  int n_fail = 0;
  logic last_ovf;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dswdt_top u_dswdt_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .strap_allow(strap_allow), .slow_tick(slow_tick),
    .sys_tick(sys_tick), .restart(restart), .ovf_pulse(ovf_pulse)
  );

  function automatic int period_of(input int src, input int code);
    return (src == 0) ? (1 << (11 + code)) : (1 << (13 + code));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic y, input logic r);
    slow_tick = s; sys_tick = y; restart = r;
    @(posedge clk); #1;
    last_ovf = ovf_pulse;
    slow_tick = 1'b0; sys_tick = 1'b0; restart = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Random gapped strobes; returns the count of selected-source ticks at the first overflow, or -1.
  task automatic measure(input int src, input int max_ticks, output int seen);
    int cnt = 0;
    seen = -1;
    while (cnt <= max_ticks) begin
      logic a = ($urandom % 4) != 0;
      logic b = $urandom % 2;
      if (src == 0) cyc(a, b, 1'b0); else cyc(b, a, 1'b0);
      if (a) cnt++;
      if (last_ovf) begin seen = cnt; break; end
    end
  endtask

  initial begin
    int seen;
    int ovf_cnt;
    void'($urandom(32'h5eed_0101));
    do_reset();

    // R1 reset state
    check(cfg_rdata == 8'h67, "R1", cfg_rdata, 8'h67);
    check(ovf_pulse == 1'b0, "R1", ovf_pulse, 0);

    // R2 wrong fixed bits rejected
    wr(8'hE0);
    check(cfg_rdata == 8'h67, "R2", cfg_rdata, 8'h67);
    wr(8'h20);
    check(cfg_rdata[7:5] == 3'b011, "R2", cfg_rdata, 8'h67);

    // R6 no strap: system and halted requests ignored
    wr(8'h68);
    check(cfg_rdata == 8'h67, "R6", cfg_rdata, 8'h67);
    wr(8'h72);
    check(cfg_rdata == 8'h67, "R6", cfg_rdata, 8'h67);

    // R10 accepted write clears partial count
    repeat (1000) cyc(1'b1, 1'b0, 1'b0);
    wr(8'h60);
    check(cfg_rdata == 8'h60, "R10", cfg_rdata, 8'h60);
    // R7 further writes locked
    wr(8'h61);
    check(cfg_rdata == 8'h60, "R7", cfg_rdata, 8'h60);

    // R3 slow source, n=0, with system strobes mixed in; R10 measured from zero
    measure(0, 5000, seen);
    check(seen == period_of(0, 0), "R3/R10", seen, period_of(0, 0));
    // R9 single-cycle pulse
    cyc(1'b0, 1'b0, 1'b0);
    check(last_ovf == 1'b0, "R9", last_ovf, 0);
    measure(0, 5000, seen);
    check(seen == period_of(0, 0), "R9 wrap", seen, period_of(0, 0));

    // R8 restart mid-period
    repeat (1500) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    measure(0, 5000, seen);
    check(seen == period_of(0, 0), "R8", seen, period_of(0, 0));
    // R8 restart coinciding with terminal tick
    ovf_cnt = 0;
    for (int i = 0; i < 2047; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      if (last_ovf) ovf_cnt++;
    end
    cyc(1'b1, 1'b0, 1'b1);
    if (last_ovf) ovf_cnt++;
    check(ovf_cnt == 0, "R8 race", ovf_cnt, 0);
    measure(0, 5000, seen);
    check(seen == period_of(0, 0), "R8 race", seen, period_of(0, 0));

    // R4 system source with strap
    do_reset();
    strap_allow = 1'b1;
    wr(8'h68);
    check(cfg_rdata == 8'h68, "R4", cfg_rdata, 8'h68);
    measure(1, 20000, seen);
    check(seen == period_of(1, 0), "R4", seen, period_of(1, 0));

    // R5 halted, code ignored
    do_reset();
    wr(8'h72);
    check(cfg_rdata == 8'h72, "R5", cfg_rdata, 8'h72);
    ovf_cnt = 0;
    for (int i = 0; i < 5000; i++) begin
      cyc(1'b1, 1'b1, 1'b0);
      if (last_ovf) ovf_cnt++;
    end
    check(ovf_cnt == 0, "R5", ovf_cnt, 0);

    // Random source/code rounds (R3, R4)
    for (int k = 0; k < 4; k++) begin
      int src = $urandom % 2;
      int code = $urandom % 2;
      logic [7:0] m = {3'b011, 1'b0, 1'(src), 3'(code)};
      do_reset();
      wr(m);
      check(cfg_rdata == m, src ? "R4" : "R3", cfg_rdata, m);
      measure(src, 40000, seen);
      check(seen == period_of(src, code), src ? "R4" : "R3", seen, period_of(src, code));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule